// File: doc/BRIEF.md
# Film cadence field-ID pulse generator

This block produces a cadence marker that lets downstream video equipment locate the film-to-video pulldown sequence. It runs on the pixel clock and listens to a one-cycle strobe issued at the leading edge of every horizontal sync pulse, a flag that marks line 1, and a field identifier. A frame counter, advanced once per frame at the start of field 1, picks the frame that opens each cadence sequence. At that frame the marker goes active.

The marker is only produced for the 29.97, 30, 59.94 and 60 frames-per-second rate classes. The sequence is 5 frames long for the lower pair and 10 frames long for the upper pair. A shape bit selects a marker that lasts one line or one that lasts the whole first field. A polarity bit inverts the registered marker at the pin. An enable bit and any change of rate class restart the sequence.

Top module: `cadence_marker_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `marker_out` equals `pol_inv` (inactive). The frame counter is cleared, so the first field-1 line-1 strobe after reset opens a sequence.
- R2: `rate_sel` codes are 3 = 29.97, 4 = 30, 6 = 59.94 and 7 = 60. With any other code, `marker_out` stays at its inactive level (`pol_inv`) from the cycle after that code is seen.
- R3: For codes 3 and 4, the marker fires on frames 0, 5, 10, ... The frames are counted from the start of the sequence, and one frame begins at each strobe with `line_one`=1 and `field_id`=0.
- R4: For codes 6 and 7, the marker fires on frames 0, 10, 20, ... of the sequence.
- R5: With `shape_field`=0, the marker becomes active in the cycle after the opening strobe (line 1, `field_id`=0). It returns inactive in the cycle after the next `hs_lead` strobe, so it spans one line.
- R6: With `shape_field`=1, the marker becomes active at the same point as in R5. It stays active through the other lines of field 1 and returns inactive in the cycle after the strobe with `line_one`=1 and `field_id`=1.
- R7: `marker_out` is the registered internal marker XOR `pol_inv`. When `pol_inv`=0 the marker is active-high. Toggling `pol_inv` changes only the output level and never shifts the cadence.
- R8: When `enable` is 0, the marker is inactive from the next cycle and the frame counter is cleared. After `enable` returns to 1, the next field-1 line-1 strobe opens a new sequence.
- R9: A change of `rate_sel` between two cycles clears the frame counter and forces the marker inactive. The next field-1 line-1 strobe opens a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Generator enable |
| hs_lead | input | 1 | One-cycle strobe at horizontal sync leading edge |
| line_one | input | 1 | High when the strobed line is line 1 of its field |
| field_id | input | 1 | 0 = field 1, 1 = field 2 |
| rate_sel | input | 3 | Frame-rate class code |
| shape_field | input | 1 | 0 = one-line marker, 1 = one-field marker |
| pol_inv | input | 1 | 0 = active-high, 1 = active-low output |
| marker_out | output | 1 | Cadence marker |

## Verification
The hardest state to reach is the tenth frame boundary of the long cadence. A missing wrap or an early wrap only shows there. The stimulus gets there by streaming twenty-one complete two-field frames and checking every frame's opening line. A second hard point is a restart that lands in the middle of an active field-long marker. The bench opens a marker in field mode and drops `enable` before the field-2 strobe. It then checks that the output falls at once and that the very next frame re-opens the sequence. Polarity is flipped in the middle of a sequence to show that the cadence phase survives.

// File: rtl/cadence_pkg.sv
package cadence_pkg;

   // Marker pulse shape
   typedef enum logic {
      SHAPE_LINE  = 1'b0,
      SHAPE_FIELD = 1'b1
   } shape_e;

   // Width needed to count 0 .. n-1
   function automatic int cnt_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/cm_rate_decode.sv
module cm_rate_decode
   import cadence_pkg::*;
#(
   parameter int RATE_W       = 3,
   parameter int CNT_W        = 4,
   parameter int CODE_S0      = 3,
   parameter int CODE_S1      = 4,
   parameter int CODE_L0      = 6,
   parameter int CODE_L1      = 7,
   parameter int SHORT_PERIOD = 5,
   parameter int LONG_PERIOD  = 10
) (
   input  logic [RATE_W-1:0] rate_sel,
   output logic              valid,
   output logic [CNT_W-1:0]  last
);

   localparam logic [CNT_W-1:0]  SHORT_LAST = CNT_W'(SHORT_PERIOD - 1);
   localparam logic [CNT_W-1:0]  LONG_LAST  = CNT_W'(LONG_PERIOD - 1);
   localparam logic [RATE_W-1:0] S0 = RATE_W'(CODE_S0);
   localparam logic [RATE_W-1:0] S1 = RATE_W'(CODE_S1);
   localparam logic [RATE_W-1:0] L0 = RATE_W'(CODE_L0);
   localparam logic [RATE_W-1:0] L1 = RATE_W'(CODE_L1);

   logic is_short;
   logic is_long;

   always_comb begin
      is_short = (rate_sel == S0) || (rate_sel == S1);
      is_long  = (rate_sel == L0) || (rate_sel == L1);
      valid    = is_short || is_long;
      if (is_long)
         last = LONG_LAST;
      else if (is_short)
         last = SHORT_LAST;
      else
         last = '0;
   end

endmodule

// File: rtl/cm_frame_counter.sv
module cm_frame_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             frame_tick,
   input  logic [CNT_W-1:0] last,
   output logic [CNT_W-1:0] cnt,
   output logic             at_zero
);

   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      if (cnt >= last)
         cnt_nxt = '0;
      else
         cnt_nxt = cnt + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst || clear)
         cnt <= '0;
      else if (frame_tick)
         cnt <= cnt_nxt;
   end

   assign at_zero = (cnt == '0);

endmodule

// File: rtl/cm_marker_shaper.sv
module cm_marker_shaper
   import cadence_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic clear,
   input  logic hs_lead,
   input  logic frame_tick,
   input  logic field2_tick,
   input  logic fire,
   input  logic shape_field,
   output logic active_q
);

   shape_e shape;
   logic   end_evt;

   always_comb begin
      shape = shape_e'(shape_field);
      unique case (shape)
         SHAPE_LINE:  end_evt = hs_lead;
         SHAPE_FIELD: end_evt = field2_tick;
         default:     end_evt = hs_lead;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst || clear)
         active_q <= 1'b0;
      else if (frame_tick)
         active_q <= fire;
      else if (end_evt)
         active_q <= 1'b0;
   end

endmodule

// File: rtl/cadence_marker_gen.sv
module cadence_marker_gen
   import cadence_pkg::*;
#(
   parameter int RATE_W       = 3,
   parameter int CODE_S0      = 3,
   parameter int CODE_S1      = 4,
   parameter int CODE_L0      = 6,
   parameter int CODE_L1      = 7,
   parameter int SHORT_PERIOD = 5,
   parameter int LONG_PERIOD  = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enable,
   input  logic              hs_lead,
   input  logic              line_one,
   input  logic              field_id,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic              shape_field,
   input  logic              pol_inv,
   output logic              marker_out
);

   localparam int MAX_PERIOD = (LONG_PERIOD > SHORT_PERIOD) ? LONG_PERIOD : SHORT_PERIOD;
   localparam int CNT_W      = cnt_width(MAX_PERIOD);

   // Elaboration-time parameter checks
   if (SHORT_PERIOD < 2 || LONG_PERIOD < 2) begin : g_bad_period
      $error("cadence_marker_gen: periods must be at least 2");
   end
   if (CODE_S0 >= (1 << RATE_W) || CODE_S1 >= (1 << RATE_W) ||
       CODE_L0 >= (1 << RATE_W) || CODE_L1 >= (1 << RATE_W)) begin : g_bad_code
      $error("cadence_marker_gen: rate code does not fit RATE_W");
   end

   logic              rate_ok;
   logic [CNT_W-1:0]  cnt_last;
   logic [CNT_W-1:0]  cnt_q;
   logic              cnt_zero;
   logic [RATE_W-1:0] rate_q;
   logic              rate_chg;
   logic              clear;
   logic              frame_tick;
   logic              field2_tick;
   logic              active_q;

   cm_rate_decode #(
      .RATE_W      (RATE_W),
      .CNT_W       (CNT_W),
      .CODE_S0     (CODE_S0),
      .CODE_S1     (CODE_S1),
      .CODE_L0     (CODE_L0),
      .CODE_L1     (CODE_L1),
      .SHORT_PERIOD(SHORT_PERIOD),
      .LONG_PERIOD (LONG_PERIOD)
   ) u_dec (
      .rate_sel(rate_sel),
      .valid   (rate_ok),
      .last    (cnt_last)
   );

   always_ff @(posedge clk) begin
      if (rst)
         rate_q <= rate_sel;
      else
         rate_q <= rate_sel;
   end

   assign rate_chg    = (rate_sel != rate_q);
   assign clear       = !enable || !rate_ok || rate_chg;
   assign frame_tick  = hs_lead && line_one && !field_id;
   assign field2_tick = hs_lead && line_one && field_id;

   cm_frame_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .clear     (clear),
      .frame_tick(frame_tick),
      .last      (cnt_last),
      .cnt       (cnt_q),
      .at_zero   (cnt_zero)
   );

   cm_marker_shaper u_shp (
      .clk        (clk),
      .rst        (rst),
      .clear      (clear),
      .hs_lead    (hs_lead),
      .frame_tick (frame_tick),
      .field2_tick(field2_tick),
      .fire       (cnt_zero),
      .shape_field(shape_field),
      .active_q   (active_q)
   );

   // Polarity applied last, on the registered marker
   assign marker_out = active_q ^ pol_inv;

endmodule

// File: rtl/cadence_marker_chk.sv
module cadence_marker_chk #(
   parameter int RATE_W  = 3,
   parameter int CNT_W   = 4,
   parameter int CODE_S0 = 3,
   parameter int CODE_S1 = 4,
   parameter int CODE_L0 = 6,
   parameter int CODE_L1 = 7,
   parameter int MAX_PERIOD = 10
) (
   input logic              clk,
   input logic              rst,
   input logic              enable,
   input logic              hs_lead,
   input logic              line_one,
   input logic              field_id,
   input logic [RATE_W-1:0] rate_sel,
   input logic              shape_field,
   input logic              pol_inv,
   input logic              marker_out,
   input logic              active_q,
   input logic [CNT_W-1:0]  cnt_q
);

   logic supported;
   assign supported = (rate_sel == RATE_W'(CODE_S0)) || (rate_sel == RATE_W'(CODE_S1)) ||
                      (rate_sel == RATE_W'(CODE_L0)) || (rate_sel == RATE_W'(CODE_L1));

   // R3
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q < CNT_W'(MAX_PERIOD));

   // R2
   unsupported_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !supported |=> (marker_out == pol_inv));

   // R8
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !enable |=> (marker_out == pol_inv));

   // R5
   rise_on_frame_start_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(active_q) |-> $past(hs_lead && line_one && !field_id));

   // R5
   line_shape_end_chk: assert property (@(posedge clk) disable iff (rst)
      (active_q && !shape_field && hs_lead && !line_one) |=> !active_q);

   // R6
   field_shape_end_chk: assert property (@(posedge clk) disable iff (rst)
      (active_q && shape_field && hs_lead && line_one && field_id) |=> !active_q);

   // R9
   rate_change_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (rate_sel != $past(rate_sel)) |-> ##0 1'b1 ##1 (cnt_q == '0 && !active_q));

endmodule

bind cadence_marker_gen cadence_marker_chk #(
   .RATE_W    (RATE_W),
   .CNT_W     (CNT_W),
   .CODE_S0   (CODE_S0),
   .CODE_S1   (CODE_S1),
   .CODE_L0   (CODE_L0),
   .CODE_L1   (CODE_L1),
   .MAX_PERIOD(MAX_PERIOD)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .enable     (enable),
   .hs_lead    (hs_lead),
   .line_one   (line_one),
   .field_id   (field_id),
   .rate_sel   (rate_sel),
   .shape_field(shape_field),
   .pol_inv    (pol_inv),
   .marker_out (marker_out),
   .active_q   (active_q),
   .cnt_q      (cnt_q)
);

// File: tb/cadence_marker_gen_test.sv
module cadence_marker_gen_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       enable = 1'b0;
   logic       hs_lead = 1'b0;
   logic       line_one = 1'b0;
   logic       field_id = 1'b0;
   logic [2:0] rate_sel = 3'd4;
   logic       shape_field = 1'b0;
   logic       pol_inv = 1'b0;
   logic       marker_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   cadence_marker_gen uut (
      .clk        (clk),
      .rst        (rst),
      .enable     (enable),
      .hs_lead    (hs_lead),
      .line_one   (line_one),
      .field_id   (field_id),
      .rate_sel   (rate_sel),
      .shape_field(shape_field),
      .pol_inv    (pol_inv),
      .marker_out (marker_out)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: marker_out=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // One-cycle strobe, then sample after the capturing edge
   task automatic strobe(input logic l1, input logic fid);
      @(negedge clk);
      hs_lead = 1'b1; line_one = l1; field_id = fid;
      @(negedge clk);
      hs_lead = 1'b0; line_one = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Two-field frame, checking the marker after every strobe
   task automatic run_frame(input string req, input logic fire);
      strobe(1'b1, 1'b0);
      check(req, marker_out, fire ^ pol_inv);
      idle(2);
      check(req, marker_out, fire ^ pol_inv);
      strobe(1'b0, 1'b0);
      check(req, marker_out, (fire && shape_field) ^ pol_inv);
      idle(1);
      strobe(1'b0, 1'b0);
      check(req, marker_out, (fire && shape_field) ^ pol_inv);
      strobe(1'b1, 1'b1);
      check(req, marker_out, pol_inv);
      strobe(1'b0, 1'b1);
      check(req, marker_out, pol_inv);
   endtask

   task automatic do_reset(input logic pol);
      @(negedge clk);
      rst = 1'b1; pol_inv = pol;
      idle(2);
      check("R1 in reset", marker_out, pol);
      rst = 1'b0;
      @(negedge clk);
      check("R1 after reset", marker_out, pol);
   endtask

   task automatic test_reset();
      enable = 1'b1; rate_sel = 3'd4; shape_field = 1'b0;
      do_reset(1'b1);
      do_reset(1'b0);
      run_frame("R1 first frame fires", 1'b1);
   endtask

   task automatic test_short(input logic [2:0] code);
      do_reset(1'b0);
      rate_sel = code; enable = 1'b1; shape_field = 1'b0;
      idle(2);
      for (int f = 0; f < 11; f++)
         run_frame("R3 short cadence", (f % 5) == 0);
   endtask

   task automatic test_long(input logic [2:0] code);
      do_reset(1'b0);
      rate_sel = code; enable = 1'b1; shape_field = 1'b0;
      idle(2);
      for (int f = 0; f < 21; f++)
         run_frame("R4 long cadence", (f % 10) == 0);
   endtask

   task automatic test_line_shape();
      do_reset(1'b0);
      rate_sel = 3'd7; enable = 1'b1; shape_field = 1'b0;
      idle(2);
      strobe(1'b1, 1'b0);
      check("R5 set on line 1", marker_out, 1'b1);
      idle(5);
      check("R5 held through line", marker_out, 1'b1);
      strobe(1'b0, 1'b0);
      check("R5 cleared at next strobe", marker_out, 1'b0);
   endtask

   task automatic test_field_shape();
      do_reset(1'b0);
      rate_sel = 3'd3; enable = 1'b1; shape_field = 1'b1;
      idle(2);
      for (int f = 0; f < 6; f++)
         run_frame("R6 field shape", (f % 5) == 0);
   endtask

   task automatic test_unsupported();
      do_reset(1'b0);
      enable = 1'b1; shape_field = 1'b1;
      rate_sel = 3'd2;
      idle(2);
      for (int f = 0; f < 3; f++) run_frame("R2 code 2 quiet", 1'b0);
      rate_sel = 3'd5;
      idle(2);
      for (int f = 0; f < 3; f++) run_frame("R2 code 5 quiet", 1'b0);
      pol_inv = 1'b1;
      rate_sel = 3'd0;
      idle(2);
      for (int f = 0; f < 2; f++) run_frame("R2 code 0 quiet inverted", 1'b0);
      pol_inv = 1'b0;
   endtask

   task automatic test_enable();
      do_reset(1'b0);
      rate_sel = 3'd6; enable = 1'b1; shape_field = 1'b1;
      idle(2);
      strobe(1'b1, 1'b0);
      check("R8 marker opened", marker_out, 1'b1);
      enable = 1'b0;
      @(negedge clk);
      check("R8 disable forces inactive", marker_out, 1'b0);
      run_frame("R8 disabled no marker", 1'b0);
      enable = 1'b1;
      idle(1);
      run_frame("R8 restart fires", 1'b1);
      run_frame("R8 restart then counts", 1'b0);
   endtask

   task automatic test_rate_change();
      do_reset(1'b0);
      rate_sel = 3'd4; enable = 1'b1; shape_field = 1'b0;
      idle(2);
      run_frame("R9 before change", 1'b1);
      run_frame("R9 before change", 1'b0);
      rate_sel = 3'd3;
      idle(1);
      run_frame("R9 change restarts", 1'b1);
      run_frame("R9 after restart", 1'b0);
   endtask

   task automatic test_polarity();
      do_reset(1'b0);
      rate_sel = 3'd3; enable = 1'b1; shape_field = 1'b0;
      idle(2);
      for (int f = 0; f < 3; f++) run_frame("R7 before flip", f == 0);
      @(negedge clk);
      pol_inv = 1'b1;
      #0.1;
      check("R7 flip changes level only", marker_out, 1'b1);
      for (int f = 3; f < 6; f++) run_frame("R7 cadence kept", (f % 5) == 0);
      pol_inv = 1'b0;
   endtask

   initial begin
      idle(3);
      test_reset();
      test_short(3'd4);
      test_short(3'd3);
      test_long(3'd6);
      test_long(3'd7);
      test_line_shape();
      test_field_shape();
      test_unsupported();
      test_enable();
      test_rate_change();
      test_polarity();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 150000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual running expected done");
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule